// File: doc/BRIEF.md
# Countdown-Status Bus Slave Wrapper

This wrapper connects a simple on-chip bus master to a memory or peripheral whose latency varies from access to access. It does not answer with a single ready or wait bit. Instead it publishes a two-bit count of the cycles still needed before the current read data or write completion is available. A master that sees the count fall to 1 can restart its pipeline early and issue its next strobe in that same cycle.

The wrapper registers the address, the write data and the direction when it accepts a strobe, so the master may move on at once. The back end receives a one-cycle request pulse together with those held values. It reports progress through a latency-estimate input and marks completion with a done pulse. Read data stays in a wrapper register until a later read completes and overwrites it. A strobe that arrives during the last cycle of a transaction is parked in a single slot and launched when the back end finishes.

Top module: `cdw_slave`

## Requirements
- R1: After reset `m_remain` is 0, `m_rdata` is 0 and `b_req` is low.
- R2: A strobe is accepted when `m_remain` is 0, or when `m_remain` is 1 and no request is parked. In the cycle after an accepted strobe starts a transaction, `b_req` is high for one cycle and `m_remain` reads 3.
- R3: The address, write data and direction are captured in the cycle of acceptance. `b_addr`, `b_we` and `b_wdata` hold those values until the done pulse, whatever the master drives afterwards. `b_we` = 1 means write.
- R4: While a transaction is open and no done pulse arrives, the next `m_remain` is `b_est` saturated at 3. It is limited to no more than the current value and to no less than 1, so the count never rises and never reaches 0 without completion.
- R5: A done pulse moves `m_remain` to 0 in the next cycle, unless a new transaction starts in that same cycle. This also applies when done comes in the same cycle as `b_req`.
- R6: When a read completes, `m_rdata` takes `b_rdata` in the next cycle and keeps it until the next read completes. Completion of a write leaves `m_rdata` unchanged.
- R7: A strobe accepted at `m_remain` = 1 without a done pulse in that cycle is parked. When done arrives, the parked request is launched: `b_req` pulses with its address and `m_remain` reads 3.
- R8: A strobe is ignored, with no `b_req` produced for it, while `m_remain` is 2 or 3, or while a request is parked.
- R9: If `m_rd` and `m_wr` are both high, the strobe is a read.
- R10: A done pulse while no transaction is open changes neither `m_remain` nor `m_rdata`.
- R11: A strobe at `m_remain` = 1 in the same cycle as done starts at once, without parking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_addr | input | ADDR_W | Master address |
| m_rd | input | 1 | Master read strobe |
| m_wr | input | 1 | Master write strobe |
| m_wdata | input | DATA_W | Master write data |
| m_rdata | output | DATA_W | Held read result |
| m_remain | output | 2 | Cycles remaining; 0 done, 3 unknown or at least three |
| b_req | output | 1 | One-cycle request pulse to the back end |
| b_we | output | 1 | Direction of the open transaction, 1 = write |
| b_addr | output | ADDR_W | Address of the open transaction |
| b_wdata | output | DATA_W | Write data of the open transaction |
| b_rdata | input | DATA_W | Back-end read data, valid with done |
| b_done | input | 1 | Back-end completion pulse |
| b_est | input | EST_W | Back-end estimate of remaining cycles |

## Verification
Two events can fall in the same cycle: the back end's completion of one transaction and the start of the next one. The next one is either a parked request or a strobe issued at a count of 1. The bench provokes both. In one case it parks a read and then pulses done. In the other it raises a write strobe and done together. In both it judges that the old read data lands in `m_rdata`, that `m_remain` jumps straight to 3 instead of 0, and that the scoreboard receives the new request's address on `b_req`.

// File: rtl/cdw_pkg.sv
`timescale 1ns/1ps
package cdw_pkg;
    typedef logic [1:0] remain_t;
    localparam remain_t REM_DONE    = 2'd0;
    localparam remain_t REM_LAST    = 2'd1;
    localparam remain_t REM_UNKNOWN = 2'd3;
endpackage

// File: rtl/cdw_req_slot.sv
`timescale 1ns/1ps
module cdw_req_slot #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  cdw_pkg::remain_t  cnt_i,
    input  logic              done_raw_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              launch_o,
    output logic              req_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o
);
    import cdw_pkg::*;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } req_t;

    typedef struct packed {
        logic busy;
        logic pend;
        logic req;
        req_t act;
        req_t park;
    } slot_t;

    slot_t st_d, st_q;
    req_t  incoming;
    logic  accept;
    logic  done_ev;
    logic  launch;

    always_comb begin
        incoming.we    = wr_i & ~rd_i;
        incoming.addr  = addr_i;
        incoming.wdata = wdata_i;
        done_ev = st_q.busy & done_raw_i;
        accept  = (rd_i | wr_i) & (cnt_i <= REM_LAST) & ~st_q.pend;
        st_d    = st_q;
        st_d.req = 1'b0;
        launch  = 1'b0;
        if (!st_q.busy) begin
            if (accept) begin
                st_d.act  = incoming;
                st_d.busy = 1'b1;
                st_d.req  = 1'b1;
                launch    = 1'b1;
            end
        end else if (done_ev) begin
            if (st_q.pend) begin
                st_d.act  = st_q.park;
                st_d.pend = 1'b0;
                st_d.req  = 1'b1;
                launch    = 1'b1;
            end else if (accept) begin
                st_d.act  = incoming;
                st_d.req  = 1'b1;
                launch    = 1'b1;
            end else begin
                st_d.busy = 1'b0;
            end
        end else if (accept) begin
            st_d.park = incoming;
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o   = st_q.busy;
    assign done_o   = done_ev;
    assign launch_o = launch;
    assign req_o    = st_q.req;
    assign we_o     = st_q.act.we;
    assign addr_o   = st_q.act.addr;
    assign wdata_o  = st_q.act.wdata;

    assert_act_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !done_raw_i) |=> $stable(st_q.act));
    assert_park_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |-> st_q.busy);
    assert_req_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.req |-> st_q.busy);
endmodule

// File: rtl/cdw_countdown.sv
`timescale 1ns/1ps
module cdw_countdown #(
    parameter int EST_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy_i,
    input  logic             done_i,
    input  logic             launch_i,
    input  logic [EST_W-1:0] est_i,
    output cdw_pkg::remain_t cnt_o
);
    import cdw_pkg::*;

    remain_t cnt_d, cnt_q;
    remain_t est_sat;
    remain_t lowered;

    generate
        if (EST_W <= 2) begin : g_narrow
            assign est_sat = remain_t'(est_i);
        end else begin : g_wide
            assign est_sat = (est_i > EST_W'(3)) ? REM_UNKNOWN : est_i[1:0];
        end
    endgenerate

    always_comb begin
        lowered = (est_sat < cnt_q) ? est_sat : cnt_q;
        if (lowered == REM_DONE) begin
            lowered = REM_LAST;
        end
        if (launch_i) begin
            cnt_d = REM_UNKNOWN;
        end else if (busy_i && !done_i) begin
            cnt_d = lowered;
        end else begin
            cnt_d = REM_DONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= REM_DONE;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

    assert_no_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !done_i && !launch_i) |=> (cnt_q <= $past(cnt_q) && cnt_q != REM_DONE));
    assert_done_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !launch_i) |=> (cnt_q == REM_DONE));
    assert_launch_unknown_R2: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |=> (cnt_q == REM_UNKNOWN));
endmodule

// File: rtl/cdw_rdata_hold.sv
`timescale 1ns/1ps
module cdw_rdata_hold #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (done_i && !we_i) begin
            hold_d = rdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign rdata_o = hold_q;

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_i && !we_i) |=> $stable(hold_q));
endmodule

// File: rtl/cdw_slave.sv
`timescale 1ns/1ps
module cdw_slave #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int EST_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic              m_rd,
    input  logic              m_wr,
    input  logic [DATA_W-1:0] m_wdata,
    output logic [DATA_W-1:0] m_rdata,
    output logic [1:0]        m_remain,
    output logic              b_req,
    output logic              b_we,
    output logic [ADDR_W-1:0] b_addr,
    output logic [DATA_W-1:0] b_wdata,
    input  logic [DATA_W-1:0] b_rdata,
    input  logic              b_done,
    input  logic [EST_W-1:0]  b_est
);
    import cdw_pkg::*;

    remain_t cnt;
    logic    busy;
    logic    done_ev;
    logic    launch;

    cdw_req_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_i       (m_rd),
        .wr_i       (m_wr),
        .addr_i     (m_addr),
        .wdata_i    (m_wdata),
        .cnt_i      (cnt),
        .done_raw_i (b_done),
        .busy_o     (busy),
        .done_o     (done_ev),
        .launch_o   (launch),
        .req_o      (b_req),
        .we_o       (b_we),
        .addr_o     (b_addr),
        .wdata_o    (b_wdata)
    );

    cdw_countdown #(.EST_W(EST_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy_i   (busy),
        .done_i   (done_ev),
        .launch_i (launch),
        .est_i    (b_est),
        .cnt_o    (cnt)
    );

    cdw_rdata_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .done_i  (done_ev),
        .we_i    (b_we),
        .rdata_i (b_rdata),
        .rdata_o (m_rdata)
    );

    assign m_remain = cnt;

    assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_remain >= 2'd2 && !b_done) |=> !b_req);
    assert_idle_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_remain == 2'd0 && !m_rd && !m_wr) |=> (m_remain == 2'd0 && $stable(m_rdata)));
endmodule

// File: tb/cdw_slave_tb.sv
`timescale 1ns/1ps
module cdw_slave_tb;
    typedef struct {
        logic        we;
        logic [15:0] addr;
        logic [31:0] wdata;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] m_addr = '0;
    logic        m_rd = 1'b0;
    logic        m_wr = 1'b0;
    logic [31:0] m_wdata = '0;
    logic [31:0] m_rdata;
    logic [1:0]  m_remain;
    logic        b_req;
    logic        b_we;
    logic [15:0] b_addr;
    logic [31:0] b_wdata;
    logic [31:0] b_rdata = '0;
    logic        b_done = 1'b0;
    logic [3:0]  b_est = 4'd3;

    int   n_run = 0;
    int   n_fail = 0;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    cdw_slave u_dut (
        .clk(clk), .rst_n(rst_n), .m_addr(m_addr), .m_rd(m_rd), .m_wr(m_wr),
        .m_wdata(m_wdata), .m_rdata(m_rdata), .m_remain(m_remain), .b_req(b_req),
        .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
        .b_done(b_done), .b_est(b_est)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic strobe(input logic rd, input logic wr, input logic [15:0] a,
                          input logic [31:0] wd, input logic expect_req);
        exp_t e;
        m_rd = rd; m_wr = wr; m_addr = a; m_wdata = wd;
        if (expect_req) begin
            e.we = wr & ~rd; e.addr = a; e.wdata = wd;
            exp_q.push_back(e);
        end
    endtask

    task automatic idle_master();
        m_rd = 1'b0; m_wr = 1'b0; m_addr = 16'hFFFF; m_wdata = 32'hDEAD_BEEF;
    endtask

    // scoreboard monitor: every request pulse must match the next queued item
    always @(negedge clk) begin
        if (rst_n && b_req) begin
            if (exp_q.size() == 0) begin
                n_run++; n_fail++;
                $display("FAIL R8: actual unexpected b_req addr %0h expected none", b_addr);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk("R2 req addr", {16'h0, b_addr}, {16'h0, e.addr});
                chk("R9 req dir", {31'h0, b_we}, {31'h0, e.we});
                if (e.we) chk("R3 req wdata", b_wdata, e.wdata);
            end
        end
    end

    initial begin
        #(8 * 20000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        chk("R1 remain", {30'h0, m_remain}, 32'h0);
        chk("R1 rdata", m_rdata, 32'h0);
        chk("R1 req", {31'h0, b_req}, 32'h0);
        rst_n = 1'b1;
        tick();

        // single read with varying estimates
        strobe(1, 0, 16'h0010, 32'h0, 1);
        tick();
        chk("R2 remain", {30'h0, m_remain}, 32'd3);
        idle_master();
        b_est = 4'd2; tick();
        chk("R4 est 2", {30'h0, m_remain}, 32'd2);
        chk("R3 addr held", {16'h0, b_addr}, 32'h10);
        b_est = 4'd3; tick();
        chk("R4 no rise", {30'h0, m_remain}, 32'd2);
        b_est = 4'd0; tick();
        chk("R4 floor 1", {30'h0, m_remain}, 32'd1);
        b_done = 1; b_rdata = 32'hAAAA; tick();
        b_done = 0; b_est = 4'd3;
        chk("R5 done", {30'h0, m_remain}, 32'd0);
        chk("R6 read data", m_rdata, 32'hAAAA);

        // write leaves held data
        strobe(0, 1, 16'h0020, 32'h55, 1);
        tick();
        idle_master();
        chk("R3 wdata held", b_wdata, 32'h55);
        b_done = 1; b_rdata = 32'h1111; tick();
        b_done = 0;
        chk("R5 write done", {30'h0, m_remain}, 32'd0);
        chk("R6 write keeps", m_rdata, 32'hAAAA);

        // strobes ignored while count is 2 or 3
        strobe(1, 0, 16'h0030, 32'h0, 1);
        tick();
        strobe(1, 0, 16'h0031, 32'h0, 0);
        b_est = 4'd15; tick();
        chk("R4 saturate", {30'h0, m_remain}, 32'd3);
        b_est = 4'd2; tick();
        chk("R8 ignored", {16'h0, b_addr}, 32'h30);
        idle_master(); b_est = 4'd3;
        b_done = 1; b_rdata = 32'hBBBB; tick();
        b_done = 0;
        chk("R6 read 2", m_rdata, 32'hBBBB);

        // parking
        strobe(1, 0, 16'h0040, 32'h0, 1);
        tick();
        idle_master(); b_est = 4'd1; tick();
        chk("R4 est 1", {30'h0, m_remain}, 32'd1);
        strobe(1, 0, 16'h0041, 32'h0, 0);
        tick();
        chk("R7 parked remain", {30'h0, m_remain}, 32'd1);
        chk("R7 no req yet", {31'h0, b_req}, 32'h0);
        strobe(1, 0, 16'h0042, 32'h0, 0);
        tick();
        idle_master();
        exp_q.push_back('{we: 1'b0, addr: 16'h0041, wdata: 32'h0});
        b_done = 1; b_rdata = 32'hCCCC; tick();
        b_done = 0;
        chk("R7 launch remain", {30'h0, m_remain}, 32'd3);
        chk("R7 old data", m_rdata, 32'hCCCC);
        b_est = 4'd0; tick();
        chk("R7 parked addr", {16'h0, b_addr}, 32'h41);
        b_done = 1; b_rdata = 32'hDDDD; tick();
        b_done = 0; b_est = 4'd3;
        chk("R5 after park", {30'h0, m_remain}, 32'd0);
        chk("R6 parked read", m_rdata, 32'hDDDD);

        // strobe at count 1 together with done
        strobe(1, 0, 16'h0050, 32'h0, 1);
        tick();
        idle_master(); b_est = 4'd1; tick();
        strobe(0, 1, 16'h0051, 32'h77, 1);
        b_done = 1; b_rdata = 32'hEEEE; tick();
        idle_master(); b_done = 0;
        chk("R11 remain", {30'h0, m_remain}, 32'd3);
        chk("R11 data", m_rdata, 32'hEEEE);
        b_done = 1; b_rdata = 32'h5555; tick();
        b_done = 0; b_est = 4'd3;
        chk("R11 write done", {30'h0, m_remain}, 32'd0);
        chk("R6 unchanged", m_rdata, 32'hEEEE);

        // both strobes high
        strobe(1, 1, 16'h0060, 32'h99, 1);
        tick();
        idle_master();
        chk("R9 direction", {31'h0, b_we}, 32'h0);
        b_done = 1; b_rdata = 32'h1234; tick();
        b_done = 0;
        chk("R9 read data", m_rdata, 32'h1234);

        // stray done while idle
        b_done = 1; b_rdata = 32'h9999; tick();
        b_done = 0;
        chk("R10 remain", {30'h0, m_remain}, 32'd0);
        chk("R10 rdata", m_rdata, 32'h1234);

        // done in the request cycle
        strobe(1, 0, 16'h0070, 32'h0, 1);
        tick();
        idle_master();
        b_done = 1; b_rdata = 32'h4321; tick();
        b_done = 0;
        chk("R5 fast done", {30'h0, m_remain}, 32'd0);
        chk("R6 fast data", m_rdata, 32'h4321);

        tick(); tick();
        chk("R2 queue drained", exp_q.size(), 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule